// File: doc/BRIEF.md
# Centralized Coherence Directory

This block is the home point of coherence for a few memory lines shared by a small group of cores. For every line it records a directory state and a presence vector, one bit per core. It also holds the backing data for each line. Caches send it point-to-point requests: a read miss, a write miss, an upgrade from a shared copy, or the write-back of a dirty line. The directory works out which other cores must give up or hand over their copies and sends probes to them. It waits until every probed core has acknowledged, then answers the requester.

The block handles one transaction at a time. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Probes go out on `prb_*`, at most one per cycle, and they are never broadcast. Each probed core answers once on `ack_*`. A recall acknowledgement also carries the line's data. The final answer is a one-cycle pulse on `rsp_*`. The line data returned with it comes from the internal array, after any recalled data has been written there.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every line has directory state not-cached, its presence vector is empty, and line i holds data INIT_BASE+i. At that point `req_ready` is high and `prb_valid` and `rsp_valid` are low.
- R2: A read miss (req_op 0) to a not-cached or shared line sends no probe. In the cycle after acceptance it returns rsp_op 0 (shared grant) with the stored data. The requester is added to the vector and the line becomes shared.
- R3: A read miss to a modified line owned by another core sends one probe with prb_op 1 (recall, keep shared) to the owner. The data in the owner's acknowledgement is written to the array and returned with rsp_op 0. Afterwards both the owner and the requester are sharers.
- R4: A write miss (req_op 1) to a shared line sends prb_op 0 (invalidate) to every other recorded sharer. Data on invalidate acknowledgements is ignored. The reply is rsp_op 1 with the stored data. Afterwards only the requester's bit is set and the line is modified.
- R5: A write miss or upgrade to a line modified by another core sends prb_op 2 (recall and invalidate) to the owner. The acknowledged data is stored and returned with rsp_op 1. The requester becomes the sole owner.
- R6: An upgrade (req_op 2) from a core recorded as a sharer of a shared line invalidates the other sharers and replies with rsp_op 2. An upgrade from a core that is not recorded as a sharer of a shared line is served exactly as a write miss, with rsp_op 1.
- R7: Probes are sent one per cycle, on consecutive cycles, in ascending core index. They go only to cores recorded in the vector, never to the requester.
- R8: The reply waits until every probed core has acknowledged. An acknowledgement from a core that was not probed is not counted. Acknowledgements may arrive in the same cycle as later probes.
- R9: `req_ready` is low from the cycle after acceptance through the reply cycle, and it is high again in the cycle after the reply.
- R10: A write-back (req_op 3) from the owner of a modified line stores `req_wdata` and returns the line to not-cached with an empty vector. Any other write-back changes nothing. Every write-back is answered with rsp_op 3 in the cycle after acceptance.
- R11: `rsp_valid` lasts exactly one cycle and is never high together with `prb_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory idle and able to take a request |
| req_core | input | $clog2(NCORE) | Requesting core |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 upgrade, 3 write-back |
| req_line | input | $clog2(NLINE) | Line index |
| req_wdata | input | DW | Write-back data |
| prb_valid | output | 1 | Probe message present |
| prb_core | output | $clog2(NCORE) | Probed core |
| prb_op | output | 2 | 0 invalidate, 1 recall keep shared, 2 recall and invalidate |
| prb_line | output | $clog2(NLINE) | Probed line |
| ack_valid | input | 1 | Probe acknowledgement present |
| ack_core | input | $clog2(NCORE) | Acknowledging core |
| ack_data | input | DW | Line data returned by a recall |
| rsp_valid | output | 1 | Reply pulse |
| rsp_core | output | $clog2(NCORE) | Core being answered |
| rsp_op | output | 2 | 0 shared grant, 1 modified grant, 2 upgrade grant, 3 write-back done |
| rsp_line | output | $clog2(NLINE) | Line being answered |
| rsp_data | output | DW | Line data |

## Verification
Probe issue and acknowledgement counting can fall in the same cycle. This happens when a probed core answers at once while the directory is still sending probes to higher-numbered sharers. The bench provokes this by acknowledging each probe in the very cycle it appears. It also alternates with a late mode, in which all acknowledgements are held back until every probe has gone out and are preceded by a stray acknowledgement from the requester. In both modes the reply must arrive only after the last real acknowledgement. The probe set must equal the sharers minus the requester, and the returned data must match a reference built from the requirements over a long pseudo-random stream of cores, lines and operations.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [1:0] {DIR_NC = 2'd0, DIR_SH = 2'd1, DIR_MD = 2'd2} dir_st_e;
    typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_UPG = 2'd2, OP_WB = 2'd3} req_op_e;
    typedef enum logic [1:0] {PK_INV = 2'd0, PK_RCL_S = 2'd1, PK_RCL_I = 2'd2} prb_op_e;
    typedef enum logic [1:0] {RK_SHR = 2'd0, RK_MOD = 2'd1, RK_UPG = 2'd2, RK_WBD = 2'd3} rsp_op_e;
    typedef enum logic [1:0] {CT_IDLE = 2'd0, CT_PROBE = 2'd1, CT_RESP = 2'd2} ctl_e;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dir_popcnt.sv
module dir_popcnt #(
    parameter int N  = 4,
    parameter int OW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [OW-1:0] cnt
);
    logic [OW-1:0] part [N+1];
    assign part[0] = '0;
    for (genvar g = 0; g < N; g++) begin : g_acc
        assign part[g+1] = part[g] + OW'(bits[g]);
    end
    assign cnt = part[N];
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NCORE     = 4,
    parameter int NLINE     = 4,
    parameter int DW        = 8,
    parameter int INIT_BASE = 160
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [$clog2(NCORE)-1:0] req_core,
    input  logic [1:0]               req_op,
    input  logic [$clog2(NLINE)-1:0] req_line,
    input  logic [DW-1:0]            req_wdata,
    output logic                     prb_valid,
    output logic [$clog2(NCORE)-1:0] prb_core,
    output logic [1:0]               prb_op,
    output logic [$clog2(NLINE)-1:0] prb_line,
    input  logic                     ack_valid,
    input  logic [$clog2(NCORE)-1:0] ack_core,
    input  logic [DW-1:0]            ack_data,
    output logic                     rsp_valid,
    output logic [$clog2(NCORE)-1:0] rsp_core,
    output logic [1:0]               rsp_op,
    output logic [$clog2(NLINE)-1:0] rsp_line,
    output logic [DW-1:0]            rsp_data
);
    localparam int CW  = $clog2(NCORE);
    localparam int LW  = $clog2(NLINE);
    localparam int ACW = $clog2(NCORE + 1);

    typedef struct packed {
        ctl_e                         ctl;
        logic [CW-1:0]                core;
        req_op_e                      op;
        logic [LW-1:0]                line;
        logic [DW-1:0]                wdat;
        logic [NCORE-1:0]             tgt;
        logic [NCORE-1:0]             todo;
        logic [ACW-1:0]               acks_left;
        prb_op_e                      pk;
        rsp_op_e                      rk;
        logic [NLINE-1:0][1:0]        dst;
        logic [NLINE-1:0][NCORE-1:0]  vec;
        logic [NLINE-1:0][DW-1:0]     mem;
    } st_t;

    st_t q, n;

    // Reset image: every line uncached, data seeded from its index.
    function automatic st_t reset_image();
        st_t r;
        r = '0;
        r.ctl = CT_IDLE;
        for (int i = 0; i < NLINE; i++) begin
            r.dst[i] = DIR_NC;
            r.vec[i] = '0;
            r.mem[i] = DW'(INIT_BASE + i);
        end
        return r;
    endfunction

    // Decode of an incoming request against the addressed line.
    logic [1:0]       cur_st;
    logic [NCORE-1:0] cur_vec;
    logic [NCORE-1:0] req_bit;
    logic [NCORE-1:0] in_tgt;
    prb_op_e          in_pk;
    rsp_op_e          in_rk;
    logic [ACW-1:0]   in_cnt;

    always_comb begin
        cur_st  = q.dst[req_line];
        cur_vec = q.vec[req_line];
        req_bit = NCORE'(1) << req_core;
        in_tgt  = '0;
        in_pk   = PK_INV;
        in_rk   = RK_SHR;
        unique case (req_op_e'(req_op))
            OP_RD: begin
                in_rk = RK_SHR;
                in_pk = PK_RCL_S;
                if (cur_st == DIR_MD) in_tgt = cur_vec & ~req_bit;
            end
            OP_WR, OP_UPG: begin
                in_tgt = cur_vec & ~req_bit;
                in_pk  = (cur_st == DIR_MD) ? PK_RCL_I : PK_INV;
                if (req_op_e'(req_op) == OP_UPG && cur_st == DIR_SH && (cur_vec & req_bit) != '0)
                    in_rk = RK_UPG;
                else
                    in_rk = RK_MOD;
            end
            default: begin
                in_rk = RK_WBD;
            end
        endcase
    end

    dir_popcnt #(.N(NCORE), .OW(ACW)) u_cnt (
        .bits (in_tgt),
        .cnt  (in_cnt)
    );

    logic          pick_found;
    logic [CW-1:0] pick_idx;

    dir_lowbit #(.N(NCORE), .IW(CW)) u_pick (
        .vec   (q.todo),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        n         = q;
        req_ready = (q.ctl == CT_IDLE);
        prb_valid = 1'b0;
        unique case (q.ctl)
            CT_IDLE: begin
                if (req_valid) begin
                    n.core      = req_core;
                    n.op        = req_op_e'(req_op);
                    n.line      = req_line;
                    n.wdat      = req_wdata;
                    n.tgt       = in_tgt;
                    n.todo      = in_tgt;
                    n.acks_left = in_cnt;
                    n.pk        = in_pk;
                    n.rk        = in_rk;
                    n.ctl       = (in_tgt != '0) ? CT_PROBE : CT_RESP;
                end
            end
            CT_PROBE: begin
                if (pick_found) begin
                    prb_valid          = 1'b1;
                    n.todo[pick_idx]   = 1'b0;
                end
                if (ack_valid && q.tgt[ack_core] && q.acks_left != '0) begin
                    n.acks_left = q.acks_left - ACW'(1);
                    if (q.pk != PK_INV) n.mem[q.line] = ack_data;
                end
                if (n.todo == '0 && n.acks_left == '0) n.ctl = CT_RESP;
            end
            CT_RESP: begin
                unique case (q.rk)
                    RK_SHR: begin
                        n.dst[q.line] = DIR_SH;
                        n.vec[q.line] = q.vec[q.line] | (NCORE'(1) << q.core);
                    end
                    RK_MOD, RK_UPG: begin
                        n.dst[q.line] = DIR_MD;
                        n.vec[q.line] = NCORE'(1) << q.core;
                    end
                    default: begin
                        if (q.dst[q.line] == DIR_MD && q.vec[q.line][q.core]) begin
                            n.mem[q.line] = q.wdat;
                            n.dst[q.line] = DIR_NC;
                            n.vec[q.line] = '0;
                        end
                    end
                endcase
                n.tgt = '0;
                n.ctl = CT_IDLE;
            end
            default: n.ctl = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_image();
        else        q <= n;
    end

    assign prb_core  = pick_idx;
    assign prb_op    = q.pk;
    assign prb_line  = q.line;
    assign rsp_valid = (q.ctl == CT_RESP);
    assign rsp_core  = q.core;
    assign rsp_op    = q.rk;
    assign rsp_line  = q.line;
    assign rsp_data  = q.mem[q.line];
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
    parameter int NCORE = 4,
    parameter int NLINE = 4,
    parameter int CW    = $clog2(NCORE)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         prb_valid,
    input logic [CW-1:0]                prb_core,
    input logic                         rsp_valid,
    input logic [CW-1:0]                cur_core,
    input logic [NLINE-1:0][1:0]        dst_q,
    input logic [NLINE-1:0][NCORE-1:0]  vec_q
);
    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid |-> !req_ready);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11
    rsp_prb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && prb_valid));
    // R7
    probe_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid && $past(prb_valid)) |-> (prb_core > $past(prb_core)));
    // R7
    probe_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid |-> (prb_core != cur_core));

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        // R4
        mod_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dst_q[g] == 2'd2) |-> ($countones(vec_q[g]) == 1));
        // R10
        nc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dst_q[g] == 2'd0) |-> (vec_q[g] == '0));
    end
endmodule

bind dir_ctrl dir_ctrl_chk #(.NCORE(NCORE), .NLINE(NLINE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .prb_valid (prb_valid),
    .prb_core  (prb_core),
    .rsp_valid (rsp_valid),
    .cur_core  (q.core),
    .dst_q     (q.dst),
    .vec_q     (q.vec)
);

// File: tb/tb_dir_ctrl.sv
`timescale 1ns/1ps
module tb_dir_ctrl;
    localparam int NC = 4, NL = 4, DW = 8, CW = 2, LW = 2, BASE = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0, req_ready;
    logic [CW-1:0] req_core = '0;
    logic [1:0]    req_op = '0;
    logic [LW-1:0] req_line = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          prb_valid;
    logic [CW-1:0] prb_core;
    logic [1:0]    prb_op;
    logic [LW-1:0] prb_line;
    logic          ack_valid = 1'b0;
    logic [CW-1:0] ack_core = '0;
    logic [DW-1:0] ack_data = '0;
    logic          rsp_valid;
    logic [CW-1:0] rsp_core;
    logic [1:0]    rsp_op;
    logic [LW-1:0] rsp_line;
    logic [DW-1:0] rsp_data;

    dir_ctrl #(.NCORE(NC), .NLINE(NL), .DW(DW), .INIT_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_op(req_op), .req_line(req_line), .req_wdata(req_wdata),
        .prb_valid(prb_valid), .prb_core(prb_core), .prb_op(prb_op), .prb_line(prb_line),
        .ack_valid(ack_valid), .ack_core(ack_core), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_op(rsp_op),
        .rsp_line(rsp_line), .rsp_data(rsp_data)
    );

    int n_chk = 0, n_fail = 0, seq = 0;
    int m_st [NL];
    int m_vec[NL];
    int m_mem[NL];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One full transaction; late=1 holds all acks until every probe has gone out.
    task automatic txn(input int core, input int op, input int line, input int wd, input bit late);
        int st, vec, rb, tgt, pk, rk, seen, pend, last, cyc, od;
        bit got, stray;
        st = m_st[line]; vec = m_vec[line]; rb = 1 << core;
        tgt = 0; pk = 0; rk = 0;
        seen = 0; pend = 0; last = -1; cyc = 0; got = 0; stray = 0;
        seq++;
        od = (seq * 13 + core * 5 + 1) & 8'hff;
        case (op)
            0: begin rk = 0; pk = 1; if (st == 2) tgt = vec & ~rb; end
            1, 2: begin
                tgt = vec & ~rb;
                pk  = (st == 2) ? 2 : 0;
                rk  = (op == 2 && st == 1 && (vec & rb) != 0) ? 2 : 1;
            end
            default: rk = 3;
        endcase
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_core = CW'(core); req_op = 2'(op);
        req_line = LW'(line); req_wdata = DW'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);
        while (!got && cyc < 64) begin
            ack_valid = 1'b0;
            if (rsp_valid) begin
                got = 1;
                chk(seen == tgt, "R7 probed set", seen, tgt);
                chk(pend == 0, "R8 reply before all acks", pend, 0);
                chk(rsp_core == CW'(core), "R2 reply core", rsp_core, core);
                chk(rsp_line == LW'(line), "R2 reply line", rsp_line, line);
                chk(rsp_op == 2'(rk), "R6 reply op", rsp_op, rk);
                if (op != 3)
                    chk(rsp_data == DW'(m_mem[line]), "R2 (R1 init, R3 R4 R5) reply data",
                        rsp_data, m_mem[line]);
                chk(!prb_valid, "R11 probe with reply", prb_valid, 0);
                chk(!req_ready, "R9 ready in reply", req_ready, 0);
            end else begin
                if (prb_valid) begin
                    chk(((tgt >> prb_core) & 1) == 1, "R7 probe target", prb_core, tgt);
                    chk(int'(prb_core) > last, "R7 ascending order", prb_core, last + 1);
                    chk(prb_op == 2'(pk), "R5 probe op", prb_op, pk);
                    chk(prb_line == LW'(line), "R7 probe line", prb_line, line);
                    last = prb_core;
                    seen |= 1 << prb_core;
                    if (!late) begin
                        ack_valid = 1'b1; ack_core = prb_core;
                        ack_data = (pk == 0) ? DW'(8'h5A ^ prb_core) : DW'(od);
                    end else pend |= 1 << prb_core;
                    if (pk != 0) m_mem[line] = od;
                end else begin
                    chk(seen == tgt, "R7 gap in probe stream", seen, tgt);
                    if (late && tgt != 0) begin
                        if (!stray) begin
                            stray = 1; ack_valid = 1'b1; ack_core = CW'(core); ack_data = 8'hEE;
                        end else if (pend != 0) begin
                            for (int i = 0; i < NC; i++) begin
                                if (ack_valid == 1'b0 && ((pend >> i) & 1) == 1) begin
                                    ack_valid = 1'b1; ack_core = CW'(i);
                                    ack_data = (pk == 0) ? DW'(8'hC3 ^ i) : DW'(od);
                                    pend &= ~(1 << i);
                                end
                            end
                        end
                    end
                end
                @(negedge clk);
                cyc++;
            end
        end
        chk(got, "R8 reply arrived", got, 1);
        // reference update
        case (rk)
            0: begin m_st[line] = 1; m_vec[line] = vec | rb; end
            1, 2: begin m_st[line] = 2; m_vec[line] = rb; end
            default: if (st == 2 && (vec & rb) != 0) begin
                m_mem[line] = wd & 8'hff; m_st[line] = 0; m_vec[line] = 0;
            end
        endcase
        @(negedge clk);
        chk(!rsp_valid, "R11 reply one cycle", rsp_valid, 0);
        chk(req_ready, "R9 ready after reply", req_ready, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_vec[i] = 0; m_mem[i] = BASE + i; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(prb_valid == 1'b0, "R1 no probe after reset", prb_valid, 0);
        chk(rsp_valid == 1'b0, "R1 no reply after reset", rsp_valid, 0);
        // directed walk on line 0: sharing, ownership, recall, upgrade, write-back
        txn(0, 0, 0, 0, 0);
        txn(2, 0, 0, 0, 1);
        txn(1, 1, 0, 0, 0);
        txn(2, 0, 0, 0, 1);
        txn(1, 2, 0, 0, 0);
        txn(3, 1, 0, 0, 1);
        txn(0, 3, 0, 8'h11, 0);
        txn(3, 3, 0, 8'h77, 0);
        txn(0, 0, 0, 0, 0);
        // four sharers then a write from the middle: three invalidations
        for (int c = 0; c < NC; c++) txn(c, 0, 1, 0, 0);
        txn(2, 1, 1, 0, 0);
        for (int c = 0; c < NC; c++) txn(c, 0, 2, 0, 1);
        txn(0, 2, 2, 0, 1);
        txn(3, 2, 3, 0, 0);
        // pseudo-random sweep over cores, lines, operations and ack modes
        lf = 16'hACE1;
        for (int k = 0; k < 1500; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            txn(int'(lf[1:0]), int'(lf[3:2]), int'(lf[5:4]), int'(lf[13:6]), lf[14]);
        end
        summary();
        $finish;
    end
endmodule